// File: doc/BRIEF.md
# Voice Block Chain Sequencer

This block turns a voice group number into an ordered stream of samples for a downstream decoder. Sample memory is cut into fixed-size voice blocks, 512 bytes each by default. A group is not one contiguous address range. It is a chain of block numbers kept in a shared entry table. Chains may jump around memory, and one block can appear in several groups. A typical case is one short phrase that is played alone, after a sound effect, or in front of a piece of music.

A single synchronous table memory holds two regions. Words `0..GROUPS-1` are group pointers, and the low bits of each give the index of that group's first entry. Words `GROUPS+i` are chain entries. Bits `[BLK_W-1:0]` of an entry give the block number, and bit `TBL_W-1` flags the final entry of the chain. The sequencer reads the pointer and then walks the entries, keeping one entry of lookahead. It fetches sample bytes at `block*BLK_BYTES + offset`, with the offset running upward. It keeps one byte buffered ahead of the sample-rate tick. On each tick it offers one item on a valid/ready output: a whole byte in PCM mode, or a nibble in ADPCM mode (low nibble, then high nibble). Back-pressure rule: an item stays on `out_data` until `out_ready` takes it. A tick that arrives while the item is still held, and not accepted in that cycle, is ignored. No data is lost; the stream only shifts later in time. Ticks must be at least three clocks apart.

Top module: `vbc_seq`

## Requirements
- R1: After reset `busy`, `out_valid`, `done`, `tbl_rd_en` and `mem_rd_en` are all low, and neither memory is read while `busy` is low.
- R2: An accepted `start` reads the table at address `group_sel` in the next cycle. The walk then reads entries at `GROUPS + pointer + k` in order and stops after the entry whose bit `TBL_W-1` is set.
- R3: Sample reads go to address `block*BLK_BYTES + offset`, with offsets `0..BLK_BYTES-1` ascending inside each block, and blocks in chain order.
- R4: With `adpcm_mode` low, each item is one whole sample byte, in memory read order.
- R5: With `adpcm_mode` high, each byte yields two items: bits 3:0 first, then bits 7:4. Each nibble appears on `out_data[3:0]` with `out_data[7:4]` zero.
- R6: While `out_valid` is high and `out_ready` low, `out_data` stays unchanged. Ticks seen during that time are ignored, and the stream resumes with no item lost or repeated.
- R7: `done` is a one-cycle pulse in the cycle right after the final item is accepted. `busy` is low in that same cycle.
- R8: `abort` brings `busy` and `out_valid` low in the next cycle and raises no `done`. Further ticks give no items, and a later `start` plays normally.
- R9: A `start` while `busy` is high is ignored, and the current group plays on unchanged.
- R10: With ticks spaced six clocks apart and `out_ready` high, every tick from the first one onward gives an item, across block boundaries too. A group of N items finishes after exactly N ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin playing the selected group (ignored while busy) |
| group_sel | input | $clog2(GROUPS) | Group number to play |
| adpcm_mode | input | 1 | 1: two nibble items per byte; 0: one byte item per byte |
| abort | input | 1 | Synchronous stop, back to idle with no done pulse |
| sample_tick | input | 1 | One pulse per output sample period |
| tbl_rd_en | output | 1 | Table memory read enable |
| tbl_rd_addr | output | $clog2(GROUPS+ENTRIES) | Table memory address |
| tbl_rd_data | input | TBL_W | Table read data, valid one cycle after the read |
| mem_rd_en | output | 1 | Sample memory read enable |
| mem_rd_addr | output | BLK_W+$clog2(BLK_BYTES) | Sample byte address |
| mem_rd_data | input | 8 | Sample byte, valid one cycle after the read |
| out_valid | output | 1 | Item available |
| out_ready | input | 1 | Downstream accepts the item |
| out_data | output | 8 | Byte, or nibble in bits 3:0 |
| busy | output | 1 | A group is being played |
| done | output | 1 | One-cycle pulse at normal completion |

## Verification
The bench builds the sequencer with four groups, a sixteen-entry table and four-byte blocks. With these values a block boundary, and with it the hand-over between the two lookahead slots, comes every few ticks. This brings chains of one to four blocks, block reuse across groups, the top block number 255 followed by block 0, and the final-entry stop within short runs. The same small table covers both sample modes, stalls from back-pressure, an abort partway through a group and a refused second start.

// File: rtl/vbc_pkg.sv
package vbc_pkg;

  typedef enum logic [1:0] {
    W_IDLE,
    W_PTR_REQ,
    W_PTR_CAP,
    W_RUN
  } walk_state_t;

  // Nibble picked from a byte for the nibble-per-item mode.
  function automatic logic [7:0] nib_of(input logic [7:0] b, input logic upper);
    return upper ? {4'b0000, b[7:4]} : {4'b0000, b[3:0]};
  endfunction

endpackage

// File: rtl/vbc_walker.sv
module vbc_walker
  import vbc_pkg::*;
#(
  parameter int GROUPS = 32,
  parameter int GRP_W  = 5,
  parameter int TIDX_W = 10,
  parameter int TA_W   = 10,
  parameter int TBL_W  = 16,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              fin,
  input  logic [GRP_W-1:0]  group_sel,
  output logic              tbl_rd_en,
  output logic [TA_W-1:0]   tbl_rd_addr,
  input  logic [TBL_W-1:0]  tbl_rd_data,
  input  logic              adv,
  output logic              busy,
  output logic              start_acc,
  output logic              cur_vld,
  output logic [BLK_W-1:0]  cur_blk,
  output logic              cur_last
);

  localparam int LAST_BIT = TBL_W - 1;

  walk_state_t        st;
  logic [GRP_W-1:0]   grp_q;
  logic [TIDX_W-1:0]  idx;
  logic               pend;
  logic               chain_end;
  logic               nxt_vld;
  logic [BLK_W-1:0]   nxt_blk;
  logic               nxt_last;
  logic               ent_req;
  logic [BLK_W-1:0]   e_blk;
  logic               e_last;

  assign busy      = (st != W_IDLE);
  assign start_acc = start && !abort && (st == W_IDLE);
  assign ent_req   = (st == W_RUN) && !pend && !chain_end && (!cur_vld || !nxt_vld);
  assign e_blk     = tbl_rd_data[BLK_W-1:0];
  assign e_last    = tbl_rd_data[LAST_BIT];

  always_comb begin
    tbl_rd_en   = 1'b0;
    tbl_rd_addr = '0;
    if (st == W_PTR_REQ) begin
      tbl_rd_en   = 1'b1;
      tbl_rd_addr = TA_W'(grp_q);
    end else if (ent_req) begin
      tbl_rd_en   = 1'b1;
      tbl_rd_addr = TA_W'(GROUPS) + TA_W'(idx);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= W_IDLE;
      grp_q     <= '0;
      idx       <= '0;
      pend      <= 1'b0;
      chain_end <= 1'b0;
      cur_vld   <= 1'b0;
      cur_blk   <= '0;
      cur_last  <= 1'b0;
      nxt_vld   <= 1'b0;
      nxt_blk   <= '0;
      nxt_last  <= 1'b0;
    end else if (abort || fin) begin
      st      <= W_IDLE;
      pend    <= 1'b0;
      cur_vld <= 1'b0;
      nxt_vld <= 1'b0;
    end else begin
      case (st)
        W_IDLE: begin
          if (start) begin
            grp_q     <= group_sel;
            st        <= W_PTR_REQ;
            chain_end <= 1'b0;
            pend      <= 1'b0;
            cur_vld   <= 1'b0;
            nxt_vld   <= 1'b0;
          end
        end
        W_PTR_REQ: st <= W_PTR_CAP;
        W_PTR_CAP: begin
          idx <= tbl_rd_data[TIDX_W-1:0];
          st  <= W_RUN;
        end
        default: begin
          if (ent_req) pend <= 1'b1;
          if (pend) begin
            pend      <= 1'b0;
            idx       <= idx + 1'b1;
            chain_end <= e_last;
          end
          // Two entry slots: the one being played and one of lookahead.
          if (pend && !cur_vld) begin
            cur_vld  <= 1'b1;
            cur_blk  <= e_blk;
            cur_last <= e_last;
          end else if (pend && adv) begin
            cur_vld  <= nxt_vld;
            cur_blk  <= nxt_blk;
            cur_last <= nxt_last;
            nxt_vld  <= 1'b1;
            nxt_blk  <= e_blk;
            nxt_last <= e_last;
          end else if (pend) begin
            nxt_vld  <= 1'b1;
            nxt_blk  <= e_blk;
            nxt_last <= e_last;
          end else if (adv) begin
            cur_vld  <= nxt_vld;
            cur_blk  <= nxt_blk;
            cur_last <= nxt_last;
            nxt_vld  <= 1'b0;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/vbc_fetch.sv
module vbc_fetch
  import vbc_pkg::*;
#(
  parameter int BLK_W  = 8,
  parameter int OFF_W  = 9,
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              adpcm,
  input  logic              tick,
  input  logic              cur_vld,
  input  logic [BLK_W-1:0]  cur_blk,
  input  logic              cur_last,
  output logic              adv,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [7:0]        mem_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              fin,
  output logic              done
);

  logic [OFF_W-1:0] off;
  logic             fdone;
  logic             rpend;
  logic             rlast;
  logic [7:0]       bbuf;
  logic             bfull;
  logic             blast;
  logic             half;
  logic             olast;
  logic             issue;
  logic             off_end;
  logic             hs;
  logic             slot_free;
  logic             take;

  assign off_end     = (off == {OFF_W{1'b1}});
  assign issue       = cur_vld && !fdone && !bfull && !rpend;
  assign mem_rd_en   = issue;
  assign mem_rd_addr = {cur_blk, off};
  assign adv         = issue && off_end && !cur_last;
  assign hs          = out_valid && out_ready;
  assign fin         = hs && olast;
  assign slot_free   = !out_valid || out_ready;
  assign take        = tick && slot_free && bfull;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      off       <= '0;
      fdone     <= 1'b0;
      rpend     <= 1'b0;
      rlast     <= 1'b0;
      bbuf      <= '0;
      bfull     <= 1'b0;
      blast     <= 1'b0;
      half      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      olast     <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= fin;
      if (issue) begin
        rpend <= 1'b1;
        rlast <= off_end && cur_last;
        off   <= off + 1'b1;
        if (off_end && cur_last) fdone <= 1'b1;
      end
      if (rpend) begin
        rpend <= 1'b0;
        bbuf  <= mem_rd_data;
        bfull <= 1'b1;
        blast <= rlast;
      end
      if (hs) out_valid <= 1'b0;
      if (take) begin
        out_valid <= 1'b1;
        if (!adpcm) begin
          out_data <= bbuf;
          olast    <= blast;
          bfull    <= 1'b0;
        end else if (!half) begin
          out_data <= nib_of(bbuf, 1'b0);
          olast    <= 1'b0;
          half     <= 1'b1;
        end else begin
          out_data <= nib_of(bbuf, 1'b1);
          olast    <= blast;
          half     <= 1'b0;
          bfull    <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/vbc_seq.sv
module vbc_seq #(
  parameter int GROUPS    = 32,
  parameter int ENTRIES   = 960,
  parameter int BLK_BYTES = 512,
  parameter int BLK_W     = 8,
  parameter int TBL_W     = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  input  logic [$clog2(GROUPS)-1:0]              group_sel,
  input  logic                                   adpcm_mode,
  input  logic                                   abort,
  input  logic                                   sample_tick,
  output logic                                   tbl_rd_en,
  output logic [$clog2(GROUPS+ENTRIES)-1:0]      tbl_rd_addr,
  input  logic [TBL_W-1:0]                       tbl_rd_data,
  output logic                                   mem_rd_en,
  output logic [BLK_W+$clog2(BLK_BYTES)-1:0]     mem_rd_addr,
  input  logic [7:0]                             mem_rd_data,
  output logic                                   out_valid,
  input  logic                                   out_ready,
  output logic [7:0]                             out_data,
  output logic                                   busy,
  output logic                                   done
);

  localparam int GRP_W  = $clog2(GROUPS);
  localparam int TIDX_W = $clog2(ENTRIES);
  localparam int TA_W   = $clog2(GROUPS + ENTRIES);
  localparam int OFF_W  = $clog2(BLK_BYTES);
  localparam int ADDR_W = BLK_W + OFF_W;

  logic             start_acc;
  logic             clr;
  logic             fin;
  logic             adv;
  logic             cur_vld;
  logic [BLK_W-1:0] cur_blk;
  logic             cur_last;

  assign clr = abort || start_acc;

  vbc_walker #(
    .GROUPS(GROUPS), .GRP_W(GRP_W), .TIDX_W(TIDX_W),
    .TA_W(TA_W), .TBL_W(TBL_W), .BLK_W(BLK_W)
  ) u_walk (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort), .fin(fin),
    .group_sel(group_sel), .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr),
    .tbl_rd_data(tbl_rd_data), .adv(adv), .busy(busy), .start_acc(start_acc),
    .cur_vld(cur_vld), .cur_blk(cur_blk), .cur_last(cur_last)
  );

  vbc_fetch #(
    .BLK_W(BLK_W), .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adpcm(adpcm_mode), .tick(sample_tick),
    .cur_vld(cur_vld), .cur_blk(cur_blk), .cur_last(cur_last), .adv(adv),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .fin(fin), .done(done)
  );

endmodule

// File: rtl/vbc_seq_chk.sv
module vbc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       abort,
  input logic       adpcm_mode,
  input logic       busy,
  input logic       done,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       mem_rd_en,
  input logic       tbl_rd_en
);

  a_r1_idle_no_reads: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd_en && !tbl_rd_en));

  a_r5_nibble_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && adpcm_mode) |-> (out_data[7:4] == 4'h0));

  a_r6_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !abort) |=> (out_valid && $stable(out_data)));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !out_valid && !done));

endmodule

bind vbc_seq vbc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .abort(abort), .adpcm_mode(adpcm_mode),
  .busy(busy), .done(done), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .mem_rd_en(mem_rd_en), .tbl_rd_en(tbl_rd_en)
);

// File: tb/vbc_seq_test.sv
`timescale 1ns/1ps
module vbc_seq_test;
  localparam int GROUPS = 4, ENTRIES = 16, BLK_BYTES = 4, BLK_W = 8, TBL_W = 16;
  localparam int GRP_W = 2, TA_W = 5, ADDR_W = 10;
  localparam logic [TBL_W-1:0] LAST = 16'h8000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, abort = 1'b0, adpcm_mode = 1'b0;
  logic sample_tick = 1'b0, out_ready = 1'b1;
  logic [GRP_W-1:0] group_sel = '0;
  logic tbl_rd_en; logic [TA_W-1:0] tbl_rd_addr; logic [TBL_W-1:0] tbl_rd_data;
  logic mem_rd_en; logic [ADDR_W-1:0] mem_rd_addr; logic [7:0] mem_rd_data;
  logic out_valid; logic [7:0] out_data; logic busy, done;

  logic [TBL_W-1:0] tb_tbl [GROUPS+ENTRIES];

  vbc_seq #(.GROUPS(GROUPS), .ENTRIES(ENTRIES), .BLK_BYTES(BLK_BYTES),
            .BLK_W(BLK_W), .TBL_W(TBL_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .group_sel(group_sel),
    .adpcm_mode(adpcm_mode), .abort(abort), .sample_tick(sample_tick),
    .tbl_rd_en(tbl_rd_en), .tbl_rd_addr(tbl_rd_addr), .tbl_rd_data(tbl_rd_data),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .busy(busy), .done(done)
  );

  function automatic logic [7:0] smp(input logic [ADDR_W-1:0] a);
    return 8'((int'(a) * 37 + 11) & 255);
  endfunction

  always @(posedge clk) begin
    if (tbl_rd_en) tbl_rd_data <= tb_tbl[tbl_rd_addr];
    if (mem_rd_en) mem_rd_data <= smp(mem_rd_addr);
  end

  // Monitor at the falling edge
  logic cap_clr = 1'b0;
  int cyc = 0, cap_n = 0, madr_n = 0, done_n = 0, last_hs = 0, done_cyc = 0;
  logic done_busy = 1'b0;
  logic [7:0] cap [256];
  logic [ADDR_W-1:0] madr [256];
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (cap_clr) begin
      cap_n <= 0; madr_n <= 0; done_n <= 0;
    end else begin
      if (out_valid && out_ready) begin
        if (cap_n < 256) cap[cap_n] <= out_data;
        cap_n <= cap_n + 1;
        last_hs <= cyc;
      end
      if (mem_rd_en) begin
        if (madr_n < 256) madr[madr_n] <= mem_rd_addr;
        madr_n <= madr_n + 1;
      end
      if (done) begin
        done_n <= done_n + 1; done_cyc <= cyc; done_busy <= busy;
      end
    end
  end

  int nchk = 0, nfail = 0;
  task automatic chk(input bit c, input string req, input int act, input int expv);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  logic [7:0] exp_d [256];
  logic [ADDR_W-1:0] exp_a [256];
  int exp_n = 0, expa_n = 0;

  task automatic build_exp(input int g, input bit adp);
    int idx;
    logic [TBL_W-1:0] e;
    logic [7:0] b;
    exp_n = 0; expa_n = 0;
    idx = int'(tb_tbl[g][3:0]);
    for (int k = 0; k < ENTRIES; k++) begin
      e = tb_tbl[GROUPS + idx];
      for (int o = 0; o < BLK_BYTES; o++) begin
        exp_a[expa_n] = ADDR_W'(int'(e[7:0]) * BLK_BYTES + o);
        b = smp(exp_a[expa_n]);
        expa_n++;
        if (!adp) begin exp_d[exp_n] = b; exp_n++; end
        else begin
          exp_d[exp_n] = {4'h0, b[3:0]}; exp_d[exp_n+1] = {4'h0, b[7:4]}; exp_n += 2;
        end
      end
      if (e[TBL_W-1]) break;
      idx++;
    end
  endtask

  task automatic kick(input int g, input bit adp);
    @(posedge clk); #1; cap_clr = 1'b1; adpcm_mode = adp; group_sel = GRP_W'(g); start = 1'b1;
    @(posedge clk); #1; start = 1'b0; cap_clr = 1'b0;
    repeat (10) @(posedge clk); #1;
  endtask

  task automatic tick1;
    sample_tick = 1'b1; @(posedge clk); #1; sample_tick = 1'b0;
    repeat (5) @(posedge clk); #1;
  endtask

  task automatic cmp_stream(input string req);
    chk(cap_n == exp_n, req, cap_n, exp_n);
    for (int i = 0; i < exp_n && i < cap_n; i++)
      chk(cap[i] == exp_d[i], req, int'(cap[i]), int'(exp_d[i]));
  endtask

  // Fixed tick count: R3 addresses, R4/R5 data, R7 done timing, R10 one item per tick
  task automatic run_fixed(input int g, input bit adp, input string req);
    build_exp(g, adp);
    kick(g, adp);
    repeat (exp_n) tick1;
    repeat (4) @(posedge clk); #1;
    cmp_stream(req);
    chk(madr_n == expa_n, "R3 read count", madr_n, expa_n);
    for (int i = 0; i < expa_n && i < madr_n; i++)
      chk(madr[i] == exp_a[i], "R3 address", int'(madr[i]), int'(exp_a[i]));
    chk(done_n == 1, "R10 done after exactly N ticks", done_n, 1);
    chk(done_cyc == last_hs + 1, "R7 done timing", done_cyc, last_hs + 1);
    chk(done_busy == 1'b0, "R7 busy low at done", int'(done_busy), 0);
    chk(busy == 1'b0, "R7 idle after", int'(busy), 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!busy && !out_valid && !done, "R1 outputs after reset", int'({busy, out_valid, done}), 0);
    chk(!tbl_rd_en && !mem_rd_en, "R1 no reads after reset", int'({tbl_rd_en, mem_rd_en}), 0);
  endtask

  task automatic t_tbl_addr;
    @(posedge clk); #1; group_sel = 2'd2; start = 1'b1;
    @(posedge clk); #1; start = 1'b0;
    chk(tbl_rd_en && tbl_rd_addr == 5'd2, "R2 pointer read", int'(tbl_rd_addr), 2);
    @(posedge clk); #1;
    @(posedge clk); #1;
    chk(tbl_rd_en && tbl_rd_addr == 5'd8, "R2 first entry read", int'(tbl_rd_addr), 8);
    @(posedge clk); #1; abort = 1'b1;
    @(posedge clk); #1; abort = 1'b0;
  endtask

  task automatic t_backpressure;
    logic [7:0] d0;
    int k;
    build_exp(2, 1'b0);
    kick(2, 1'b0);
    out_ready = 1'b0;
    tick1;
    d0 = out_data;
    chk(out_valid == 1'b1, "R6 item offered", int'(out_valid), 1);
    repeat (3) tick1;
    chk(out_valid && out_data == d0, "R6 item held under stall", int'(out_data), int'(d0));
    chk(cap_n == 0, "R6 nothing taken while stalled", cap_n, 0);
    k = 0;
    while (done_n == 0 && k < 300) begin
      out_ready = (k % 4 != 1);
      tick1;
      k++;
    end
    out_ready = 1'b1;
    repeat (4) @(posedge clk); #1;
    cmp_stream("R6 stream under back-pressure");
  endtask

  task automatic t_abort;
    kick(0, 1'b0);
    repeat (3) tick1;
    abort = 1'b1; @(posedge clk); #1; abort = 1'b0;
    chk(!busy && !out_valid, "R8 idle after abort", int'({busy, out_valid}), 0);
    repeat (3) tick1;
    chk(cap_n == 3, "R8 no items after abort", cap_n, 3);
    chk(done_n == 0, "R8 no done on abort", done_n, 0);
    run_fixed(3, 1'b0, "R8 restart after abort");
  endtask

  task automatic t_busy_start;
    build_exp(0, 1'b0);
    kick(0, 1'b0);
    repeat (5) tick1;
    group_sel = 2'd1; start = 1'b1; @(posedge clk); #1; start = 1'b0;
    chk(busy == 1'b1, "R9 still busy", int'(busy), 1);
    repeat (exp_n - 5) tick1;
    repeat (4) @(posedge clk); #1;
    cmp_stream("R9 stream unchanged by second start");
    chk(done_n == 1, "R9 single done", done_n, 1);
  endtask

  initial begin
    #(4 * 150000);
    nfail++; nchk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < GROUPS + ENTRIES; i++) tb_tbl[i] = '0;
    tb_tbl[0] = 16'd0; tb_tbl[1] = 16'd3; tb_tbl[2] = 16'd4; tb_tbl[3] = 16'd8;
    tb_tbl[GROUPS+0] = 16'd5;
    tb_tbl[GROUPS+1] = 16'd9;
    tb_tbl[GROUPS+2] = LAST | 16'd2;
    tb_tbl[GROUPS+3] = LAST | 16'd7;
    tb_tbl[GROUPS+4] = 16'd200;
    tb_tbl[GROUPS+5] = 16'd5;
    tb_tbl[GROUPS+6] = 16'd9;
    tb_tbl[GROUPS+7] = LAST | 16'd2;
    tb_tbl[GROUPS+8] = 16'd255;
    tb_tbl[GROUPS+9] = LAST | 16'd0;
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    t_reset;
    t_tbl_addr;
    run_fixed(0, 1'b0, "R4 PCM jumping chain");
    run_fixed(2, 1'b0, "R4 PCM reused blocks");
    run_fixed(1, 1'b1, "R5 ADPCM single entry");
    run_fixed(3, 1'b1, "R5 ADPCM block 255 then 0");
    t_backpressure;
    t_abort;
    t_busy_start;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule